// File: doc/BRIEF.md
# Six-State Self-Recovering Sequence Counter

This block is a 3-bit synchronous counter that repeats a fixed six-state sequence rather than a plain binary count. Each state bit is stored in a JK-style register and updated on the rising clock edge. The bits are named A (most significant), B and C. Two of the eight codes, 011 and 111, are never part of the loop. From either of them, the next clock edge moves the counter into the loop, and counting continues normally from there.

A control module works out the J and K strobes for each bit from the present state. A datapath module holds the three JK registers. A test-only preset port loads any code, including the two unused ones, so that recovery can be exercised.

Top module: `seq6_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` becomes 000 after that edge, whatever `presetEn` is.
- R2: When `rst` is low and `presetEn` is high at a rising edge, `count` takes the value of `presetVal` after that edge, for all eight codes.
- R3: When counting (`rst` and `presetEn` low), bit A (`count[2]`) uses J=B and K=B. It toggles when B is 1 and holds when B is 0.
- R4: When counting, bit B (`count[1]`) uses J=C and K=1. It becomes the complement of its old value when C is 1, and becomes 0 when C is 0.
- R5: When counting, bit C (`count[0]`) uses J=not B and K=1. It toggles when B is 0, and becomes 0 when B is 1.
- R6: When counting from 000, the sequence is 000, 001, 010, 100, 101, 110, and then 000 again.
- R7: One count from the unused code 011 gives 100.
- R8: One count from the unused code 111 gives 000.
- R9: After any counting edge, `count` is never 011 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All updates happen on the rising edge. |
| rst | input | 1 | Synchronous reset to 000. It has the highest priority. |
| presetEn | input | 1 | Test-only load strobe. It has priority over counting. |
| presetVal | input | 3 | Code to load when `presetEn` is high. |
| count | output | 3 | Present state {A, B, C}. |

## Verification
The block is built with its single default width of three bits, so the bench can reach all eight codes. The preset port lets the bench start from each code, including the two outside the loop. One count from each code is then compared with a next-state model written from the J/K equations, which covers recovery from 011 and 111 directly. The bench also walks two full turns of the loop and checks that reset wins over a preset in the same cycle.

// File: rtl/seq6_pkg.sv
package seq6_pkg;
  localparam int StateW = 3;
  localparam int IdxA = 2;
  localparam int IdxB = 1;
  localparam int IdxC = 0;

  typedef struct packed {
    logic [StateW-1:0] jIn;
    logic [StateW-1:0] kIn;
  } jkStrobes_t;
endpackage

// File: rtl/seq6_ctrl.sv
module seq6_ctrl
  import seq6_pkg::*;
(
  input  logic       stateB,
  input  logic       stateC,
  output jkStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    // bit A: J = K = B
    strobes.jIn[IdxA] = stateB;
    strobes.kIn[IdxA] = stateB;
    // bit B: J = C, K = 1
    strobes.jIn[IdxB] = stateC;
    strobes.kIn[IdxB] = 1'b1;
    // bit C: J = not B, K = 1
    strobes.jIn[IdxC] = ~stateB;
    strobes.kIn[IdxC] = 1'b1;
  end
endmodule

// File: rtl/seq6_dp.sv
module seq6_dp
  import seq6_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              presetEn,
  input  logic [StateW-1:0] presetVal,
  input  jkStrobes_t        strobes,
  output logic [StateW-1:0] state
);
  for (genvar i = 0; i < StateW; i++) begin : g_bit
    logic qBit;
    always_ff @(posedge clk) begin
      if (rst)           qBit <= 1'b0;
      else if (presetEn) qBit <= presetVal[i];
      else begin
        case ({strobes.jIn[i], strobes.kIn[i]})
          2'b10:   qBit <= 1'b1;
          2'b01:   qBit <= 1'b0;
          2'b11:   qBit <= ~qBit;
          default: qBit <= qBit;
        endcase
      end
    end
    assign state[i] = qBit;
  end

  // R1: reset clears every bit
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> state == '0);
  // R2: preset loads the code
  p_preset_load_r2: assert property (@(posedge clk) disable iff (rst)
    presetEn |=> state == $past(presetVal));
  // R3: bit A toggles exactly when B was set
  p_bit_a_r3: assert property (@(posedge clk) disable iff (rst)
    !presetEn |=> state[IdxA] == ($past(state[IdxB]) ? ~$past(state[IdxA]) : $past(state[IdxA])));
  // R4: bit B
  p_bit_b_r4: assert property (@(posedge clk) disable iff (rst)
    !presetEn |=> state[IdxB] == ($past(state[IdxC]) & ~$past(state[IdxB])));
  // R5: bit C
  p_bit_c_r5: assert property (@(posedge clk) disable iff (rst)
    !presetEn |=> state[IdxC] == (~$past(state[IdxB]) & ~$past(state[IdxC])));
endmodule

// File: rtl/seq6_counter.sv
module seq6_counter
  import seq6_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              presetEn,
  input  logic [StateW-1:0] presetVal,
  output logic [StateW-1:0] count
);
  jkStrobes_t strobes;

  seq6_ctrl u_ctrl (
    .stateB  (count[IdxB]),
    .stateC  (count[IdxC]),
    .strobes (strobes)
  );

  seq6_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .presetEn  (presetEn),
    .presetVal (presetVal),
    .strobes   (strobes),
    .state     (count)
  );

  // R6: loop order
  p_loop_000_r6: assert property (@(posedge clk) disable iff (rst)
    (!presetEn && count == 3'b000) |=> count == 3'b001);
  p_loop_010_r6: assert property (@(posedge clk) disable iff (rst)
    (!presetEn && count == 3'b010) |=> count == 3'b100);
  p_loop_110_r6: assert property (@(posedge clk) disable iff (rst)
    (!presetEn && count == 3'b110) |=> count == 3'b000);
  // R7, R8: recovery from the unused codes
  p_recover_011_r7: assert property (@(posedge clk) disable iff (rst)
    (!presetEn && count == 3'b011) |=> count == 3'b100);
  p_recover_111_r8: assert property (@(posedge clk) disable iff (rst)
    (!presetEn && count == 3'b111) |=> count == 3'b000);
  // R9: a counting edge always lands in the loop
  p_valid_after_count_r9: assert property (@(posedge clk) disable iff (rst)
    !presetEn |=> (count != 3'b011 && count != 3'b111));
endmodule

// File: tb/seq6_counter_bench.sv
module seq6_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       presetEn = 1'b0;
  logic [2:0] presetVal = 3'b000;
  logic [2:0] count;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seq6_counter u_seq6_counter (
    .clk(clk), .rst(rst), .presetEn(presetEn), .presetVal(presetVal), .count(count)
  );

  // next-state model from the J/K equations of R3..R5
  function automatic logic [2:0] jkNext(input logic [2:0] s);
    logic a, b, c;
    a = s[1] ? ~s[2] : s[2];
    b = s[0] ? ~s[1] : 1'b0;
    c = s[1] ? 1'b0 : ~s[0];
    return {a, b, c};
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: count=%b expected=%b", req, act, exp);
    end
  endtask

  // one edge with the given controls, sampled just after it
  task automatic step(input logic r, input logic pe, input logic [2:0] pv);
    @(negedge clk);
    rst = r; presetEn = pe; presetVal = pv;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    step(1'b1, 1'b0, 3'b000);
    chk("R1 reset", count, 3'b000);
    step(1'b0, 1'b1, 3'b101);
    step(1'b1, 1'b1, 3'b110);
    chk("R1 reset over preset", count, 3'b000);
  endtask

  task automatic testPresetAll();
    for (int v = 0; v < 8; v++) begin
      step(1'b0, 1'b1, 3'(v));
      chk("R2 preset", count, 3'(v));
    end
  endtask

  task automatic testEquations();
    for (int v = 0; v < 8; v++) begin
      step(1'b0, 1'b1, 3'(v));
      step(1'b0, 1'b0, 3'b000);
      chk("R3/R4/R5 jk step", count, jkNext(3'(v)));
      chk("R9 valid after count", 3'((count == 3'b011) || (count == 3'b111)), 3'b000);
    end
  endtask

  task automatic testLoop();
    logic [2:0] order [6];
    order = '{3'b001, 3'b010, 3'b100, 3'b101, 3'b110, 3'b000};
    step(1'b1, 1'b0, 3'b000);
    for (int t = 0; t < 12; t++) begin
      step(1'b0, 1'b0, 3'b000);
      chk("R6 loop order", count, order[t % 6]);
    end
  endtask

  task automatic testRecover();
    step(1'b0, 1'b1, 3'b011);
    step(1'b0, 1'b0, 3'b000);
    chk("R7 recover 011", count, 3'b100);
    step(1'b0, 1'b0, 3'b000);
    chk("R7 continue", count, 3'b101);
    step(1'b0, 1'b1, 3'b111);
    step(1'b0, 1'b0, 3'b000);
    chk("R8 recover 111", count, 3'b000);
    step(1'b0, 1'b0, 3'b000);
    chk("R8 continue", count, 3'b001);
  endtask

  initial begin
    testReset();
    testPresetAll();
    testEquations();
    testLoop();
    testRecover();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: count=%b expected=finished", count);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule